// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is the host-side controller for a 10-bit successive-approximation converter that sits on a three-wire serial link. It drives the converter's active-low select, its serial clock and its active-low power-down line, and it reads the converter's serial data line. A one-cycle start pulse runs one conversion. The falling select edge makes the converter hold its input. The block then clocks out the frame, skips the leading zeros, drops the sub-bits and trailing bits, and presents the 10-bit code with a one-cycle valid strobe.

Every timing figure is a count of system-clock cycles set by a parameter: the serial-clock half period, the minimum select-high time between frames, the re-acquisition wait after an aborted frame, the reference wake-up wait after power-up or power-down, and the pause between the two bytes in split mode. Three frame shapes can be picked per conversion: one 16-clock burst, two 8-clock bytes with a pause between them, or a short 13-clock frame that stops right after the last data bit. A start request that arrives while the block is busy is remembered and served once the block is idle again.

Top module: `adc_read_seq`

## Requirements
- R1: During reset and right after it, `cs_n_o` is 1, `sclk_o` is 0, `shdn_n_o` is 1 and `valid_o` is 0. No frame begins until at least WAKE_CYC cycles after reset is released.
- R2: A frame begins when `cs_n_o` falls, and `sclk_o` is high only while `cs_n_o` is low. The first rising edge of `sclk_o` comes at least DIV_HALF cycles after `cs_n_o` falls.
- R3: Inside a frame, every high phase of `sclk_o` lasts exactly DIV_HALF cycles. Every low phase between two rising edges lasts exactly DIV_HALF cycles, except the byte pause of R5.
- R4: With `mode_i` = 0 or 3 (burst), the frame has exactly 16 rising edges with no pause. `cs_n_o` rises in the same cycle that `sclk_o` falls after the 16th edge.
- R5: With `mode_i` = 1 (split), the frame has 16 rising edges. Between the 8th and 9th edges `sclk_o` stays low for exactly GAP_CYC + DIV_HALF cycles while `cs_n_o` stays low.
- R6: With `mode_i` = 2 (short), the frame ends after exactly 13 rising edges.
- R7: The converter sends three zeros, then the result MSB first, then two sub-bits, then trailing bits, each launched on a rising edge. `result_o` holds the 10 bits launched by rising edges 3 to 12, MSB first. Sub-bits and trailing bits never reach `result_o`. `valid_o` is high for exactly one cycle, the first cycle in which `cs_n_o` is back high after a completed frame.
- R8: After a completed frame, `cs_n_o` stays high for at least CSH_CYC cycles before it falls again.
- R9: When `abort_i` is high during a frame, `cs_n_o` is high in the next cycle and that frame gives no `valid_o` pulse. The next frame starts no sooner than ACQ_CYC cycles later.
- R10: While `shdn_req_i` is high and the block is idle, `shdn_n_o` is 0 and no frame starts. After `shdn_req_i` falls, no frame starts for at least WAKE_CYC cycles.
- R11: A `start_i` pulse that arrives during a frame, a wait or power-down is held. It produces exactly one later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| mode_i | input | 2 | Frame shape: 0 burst, 1 split bytes, 2 short, 3 burst |
| abort_i | input | 1 | Ends the current frame early |
| shdn_req_i | input | 1 | Level request to power the converter down |
| adc_sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| shdn_n_o | output | 1 | Active-low power-down line |
| result_o | output | RES_W | Last conversion code |
| valid_o | output | 1 | One-cycle strobe, result updated |

## Verification
A wrong edge counter or sampling window moves the captured field. The returned code then comes out shifted by one place, with a sub-bit or trailing one pulled in. The bench sends sub-bits and trailing bits as ones, so this shows at the very next `valid_o` pulse. A wrong phase or wait counter changes the high/low run lengths or the select-high gap that the bench measures within the same frame. A lost or doubled pending request shows as the wrong number of `valid_o` pulses a few hundred cycles after the request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Frame layout seen on the serial data line
    localparam int LEAD_ZEROS = 3;
    localparam int SUB_BITS   = 2;
    localparam int TRAIL_BITS = 1;
    localparam int BYTE_EDGES = 8;

    typedef enum logic [1:0] {
        FRM_BURST = 2'd0,
        FRM_BYTES = 2'd1,
        FRM_SHORT = 2'd2,
        FRM_ALT   = 2'd3
    } frame_mode_e;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_SHDN,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_CSHOLD,
        ST_ACQ
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic shdn_n;
    } pin_drive_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic pin_drive_t drive_of(input seq_state_e s);
        pin_drive_t d;
        d.cs_n   = !(s == ST_LOW || s == ST_HIGH || s == ST_GAP);
        d.sclk   = (s == ST_HIGH);
        d.shdn_n = (s != ST_SHDN);
        return d;
    endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_tick_timer.sv
module adc_tick_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= W'(INIT);
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rx_field.sv
module adc_rx_field #(
    parameter int RES_W  = 10,
    parameter int EDGE_W = 5,
    parameter int FIRST  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic [EDGE_W-1:0] next_edge_i,
    input  logic              sdi_i,
    output logic [RES_W-1:0]  field_o
);
    localparam logic [EDGE_W-1:0] E_FIRST = EDGE_W'(FIRST);
    localparam logic [EDGE_W-1:0] E_LAST  = EDGE_W'(FIRST + RES_W - 1);

    logic in_window;
    assign in_window = (next_edge_i >= E_FIRST) && (next_edge_i <= E_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear_i)            field_o <= '0;
        else if (sample_i && in_window) field_o <= {field_o[RES_W-2:0], sdi_i};
    end
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int DIV_HALF = 8,
    parameter int WAKE_CYC = 140000,
    parameter int CSH_CYC  = 10,
    parameter int ACQ_CYC  = 47,
    parameter int GAP_CYC  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             abort_i,
    input  logic             shdn_req_i,
    input  logic             adc_sdo_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             shdn_n_o,
    output logic [RES_W-1:0] result_o,
    output logic             valid_o
);
    localparam int FULL_EDGES  = LEAD_ZEROS + RES_W + SUB_BITS + TRAIL_BITS;
    localparam int SHORT_EDGES = LEAD_ZEROS + RES_W;
    localparam int EDGE_W      = cnt_width(FULL_EDGES);
    localparam int TMR_MAX     = imax(imax(WAKE_CYC, ACQ_CYC),
                                      imax(imax(CSH_CYC, GAP_CYC), DIV_HALF));
    localparam int TMR_W       = cnt_width(TMR_MAX);

    localparam logic [TMR_W-1:0] LD_PHASE = TMR_W'(DIV_HALF - 1);
    localparam logic [TMR_W-1:0] LD_WAKE  = TMR_W'(WAKE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_CSH   = TMR_W'(CSH_CYC - 1);
    localparam logic [TMR_W-1:0] LD_ACQ   = TMR_W'(ACQ_CYC - 1);
    localparam logic [TMR_W-1:0] LD_GAP   = TMR_W'(GAP_CYC - 1);
    localparam logic [EDGE_W-1:0] E_FULL  = EDGE_W'(FULL_EDGES);
    localparam logic [EDGE_W-1:0] E_SHORT = EDGE_W'(SHORT_EDGES);
    localparam logic [EDGE_W-1:0] E_BYTE  = EDGE_W'(BYTE_EDGES);

    seq_state_e        st_q, st_n;
    frame_mode_e       mode_q;
    logic [EDGE_W-1:0] edge_q, last_edge;
    logic              pend_q;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              sample, fld_clear, frame_fin, edge_inc, frame_go;
    logic              sdi_sync;
    logic [RES_W-1:0]  field;
    logic              valid_q;
    logic [RES_W-1:0]  result_q;
    pin_drive_t        pins;

    adc_bit_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (adc_sdo_i),
        .q_o (sdi_sync)
    );

    adc_tick_timer #(.W(TMR_W), .INIT(WAKE_CYC - 1)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    adc_rx_field #(.RES_W(RES_W), .EDGE_W(EDGE_W), .FIRST(LEAD_ZEROS + 1)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (fld_clear),
        .sample_i    (sample),
        .next_edge_i (edge_q + 1'b1),
        .sdi_i       (sdi_sync),
        .field_o     (field)
    );

    assign last_edge = (mode_q == FRM_SHORT) ? E_SHORT : E_FULL;

    always_comb begin
        st_n      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sample    = 1'b0;
        fld_clear = 1'b0;
        frame_fin = 1'b0;
        edge_inc  = 1'b0;
        frame_go  = 1'b0;
        unique case (st_q)
            ST_WAKE: if (tmr_done) st_n = ST_IDLE;
            ST_IDLE: begin
                if (shdn_req_i) begin
                    st_n = ST_SHDN;
                end else if (pend_q || start_i) begin
                    st_n      = ST_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PHASE;
                    fld_clear = 1'b1;
                    frame_go  = 1'b1;
                end
            end
            ST_SHDN: begin
                if (!shdn_req_i) begin
                    st_n     = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WAKE;
                end
            end
            ST_LOW: begin
                if (abort_i) begin
                    st_n = ST_ACQ; tmr_load = 1'b1; tmr_val = LD_ACQ;
                end else if (tmr_done) begin
                    sample   = 1'b1;
                    edge_inc = 1'b1;
                    st_n     = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PHASE;
                end
            end
            ST_HIGH: begin
                if (abort_i) begin
                    st_n = ST_ACQ; tmr_load = 1'b1; tmr_val = LD_ACQ;
                end else if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (edge_q == last_edge) begin
                        frame_fin = 1'b1;
                        st_n      = ST_CSHOLD;
                        tmr_val   = LD_CSH;
                    end else if (mode_q == FRM_BYTES && edge_q == E_BYTE) begin
                        st_n    = ST_GAP;
                        tmr_val = LD_GAP;
                    end else begin
                        st_n    = ST_LOW;
                        tmr_val = LD_PHASE;
                    end
                end
            end
            ST_GAP: begin
                if (abort_i) begin
                    st_n = ST_ACQ; tmr_load = 1'b1; tmr_val = LD_ACQ;
                end else if (tmr_done) begin
                    st_n = ST_LOW; tmr_load = 1'b1; tmr_val = LD_PHASE;
                end
            end
            ST_CSHOLD, ST_ACQ: if (tmr_done) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_WAKE;
            mode_q   <= FRM_BURST;
            edge_q   <= '0;
            pend_q   <= 1'b0;
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            st_q    <= st_n;
            valid_q <= frame_fin;
            if (frame_fin) result_q <= field;
            if (frame_go) begin
                mode_q <= frame_mode_e'(mode_i);
                edge_q <= '0;
            end else if (edge_inc) begin
                edge_q <= edge_q + 1'b1;
            end
            pend_q <= (pend_q && !frame_go) ||
                      (start_i && !(st_q == ST_IDLE && !shdn_req_i));
        end
    end

    assign pins     = drive_of(st_q);
    assign cs_n_o   = pins.cs_n;
    assign sclk_o   = pins.sclk;
    assign shdn_n_o = pins.shdn_n;
    assign valid_o  = valid_q;
    assign result_o = result_q;

    // Run-length counters used only by the timing assertions below
    logic [TMR_W-1:0] lo_run_q, cs_hi_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run_q    <= '0;
            cs_hi_run_q <= '0;
        end else begin
            if (!cs_n_o && !sclk_o) lo_run_q <= (lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1;
            else                    lo_run_q <= '0;
            if (cs_n_o) cs_hi_run_q <= (cs_hi_run_q == '1) ? cs_hi_run_q : cs_hi_run_q + 1'b1;
            else        cs_hi_run_q <= '0;
        end
    end

    AST_SCLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);                                                   // R2
    AST_SCLK_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (lo_run_q >= TMR_W'(DIV_HALF)));                     // R3
    AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> (cs_hi_run_q >= TMR_W'(CSH_CYC)));                    // R8
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);                                                 // R7
    AST_VALID_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cs_n_o);                                                   // R7
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (abort_i && !cs_n_o) |=> (cs_n_o && !valid_o));                        // R9
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_o |-> (cs_n_o && !sclk_o));                                    // R10
endmodule

// File: tb/adc_read_seq_tb.sv
module adc_read_seq_tb_top;
    localparam int RES_W    = 10;
    localparam int DIV_HALF = 3;
    localparam int WAKE_CYC = 40;
    localparam int CSH_CYC  = 10;
    localparam int ACQ_CYC  = 25;
    localparam int GAP_CYC  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, abort_i = 1'b0, shdn_req_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic adc_sdo = 1'b0;
    logic cs_n_o, sclk_o, shdn_n_o, valid_o;
    logic [RES_W-1:0] result_o;

    always #5 clk = ~clk;

    adc_read_seq #(.RES_W(RES_W), .DIV_HALF(DIV_HALF), .WAKE_CYC(WAKE_CYC),
                   .CSH_CYC(CSH_CYC), .ACQ_CYC(ACQ_CYC), .GAP_CYC(GAP_CYC)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .abort_i(abort_i),
        .shdn_req_i(shdn_req_i), .adc_sdo_i(adc_sdo), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .shdn_n_o(shdn_n_o), .result_o(result_o), .valid_o(valid_o)
    );

    int n_vec = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model: 3 zeros, data MSB first, then sub-bits and trailing
    // bits sent as ones so that any widened capture window is visible.
    logic [RES_W-1:0] dev_val = '0;
    int dev_k = 0;
    always @(negedge cs_n_o) begin dev_k = 0; adc_sdo = 1'b0; end
    always @(posedge sclk_o) begin
        if (!cs_n_o) begin
            dev_k = dev_k + 1;
            if (dev_k < 3)        adc_sdo = 1'b0;
            else if (dev_k <= 12) adc_sdo = dev_val[12 - dev_k];
            else                  adc_sdo = 1'b1;
        end
    end

    // Port monitor, sampled on the falling system-clock edge
    int rises = 0, lo = 0, hi = 0, max_lo = 0, min_hi = 0, max_hi = 0;
    int cs_hi_run = 0, last_cs_hi = 0, valid_cnt = 0, cs_falls = 0, cs_fall_cyc = 0;
    int valid_pos_err = 0, sclk_idle_err = 0;
    logic [RES_W-1:0] last_result = '0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n_o) begin
                if (cs_prev) begin
                    last_cs_hi = cs_hi_run; cs_falls++; cs_fall_cyc = cyc;
                    rises = 0; lo = 0; hi = 0; max_lo = 0; min_hi = 1000; max_hi = 0;
                end
                if (sclk_o) begin
                    if (!sclk_prev) begin
                        rises++;
                        if (lo > max_lo) max_lo = lo;
                        lo = 0;
                    end
                    hi++;
                end else begin
                    if (sclk_prev) begin
                        if (hi < min_hi) min_hi = hi;
                        if (hi > max_hi) max_hi = hi;
                        hi = 0;
                    end
                    lo++;
                end
            end else begin
                if (!cs_prev) begin
                    if (sclk_prev) begin
                        if (hi < min_hi) min_hi = hi;
                        if (hi > max_hi) max_hi = hi;
                    end
                    hi = 0; cs_hi_run = 0;
                end
                cs_hi_run++;
                if (sclk_o) sclk_idle_err++;
            end
            if (valid_o) begin
                valid_cnt++;
                last_result = result_o;
                if (!(cs_n_o && !cs_prev)) valid_pos_err++;
            end
            cs_prev = cs_n_o; sclk_prev = sclk_o;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic wait_valid(input int n);
        while (valid_cnt < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_frame(input int m, input logic [RES_W-1:0] v, input string tag);
        int exp_edges;
        exp_edges = (m == 2) ? 13 : 16;
        chk(last_result == v, "R7 result", int'(last_result), int'(v));
        if (m == 1) chk(rises == exp_edges, "R5 edges", rises, exp_edges);
        else if (m == 2) chk(rises == exp_edges, "R6 edges", rises, exp_edges);
        else chk(rises == exp_edges, "R4 edges", rises, exp_edges);
        if (m == 1) chk(max_lo == GAP_CYC + DIV_HALF, "R5 pause", max_lo, GAP_CYC + DIV_HALF);
        else chk(max_lo == DIV_HALF, "R3 low phase", max_lo, DIV_HALF);
        chk(min_hi == DIV_HALF && max_hi == DIV_HALF, "R3 high phase", max_hi, DIV_HALF);
        if (tag == "gap") chk(last_cs_hi >= CSH_CYC, "R8 select gap", last_cs_hi, CSH_CYC);
    endtask

    initial begin
        int base;
        int t0;
        repeat (4) @(posedge clk);
        #1;
        chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1 reset pins", {cs_n_o, sclk_o}, 2);
        chk(shdn_n_o == 1'b1 && valid_o == 1'b0, "R1 reset pins", {shdn_n_o, valid_o}, 2);
        @(posedge clk); #1 rst = 1'b0; t0 = cyc;

        // R1: start right after reset must wait for the reference
        dev_val = 10'h2A5; mode_i = 2'd0;
        pulse_start();
        wait_valid(1);
        chk(cs_fall_cyc - t0 >= WAKE_CYC, "R1 wake wait", cs_fall_cyc - t0, WAKE_CYC);
        check_frame(0, 10'h2A5, "first");

        // Sweep every code across the three frame shapes (R4 R5 R6 R7 R8)
        for (int v = 0; v < 1024; v++) begin
            dev_val = v[RES_W-1:0];
            mode_i = (v % 4 == 3) ? 2'd3 : 2'(v % 3);
            base = valid_cnt;
            pulse_start();
            wait_valid(base + 1);
            check_frame((mode_i == 2'd3) ? 0 : int'(mode_i), v[RES_W-1:0], "gap");
        end

        // R9: abort part-way, then request again at once
        dev_val = 10'h155; mode_i = 2'd0; base = valid_cnt;
        pulse_start();
        while (rises < 6 || cs_n_o) @(negedge clk);
        @(posedge clk); #1 abort_i = 1'b1;
        @(posedge clk); #1 abort_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R9 abort release", cs_n_o, 1);
        @(posedge clk); #1 start_i = 1'b0;
        wait_valid(base + 1);
        chk(last_cs_hi >= ACQ_CYC, "R9 reacquire wait", last_cs_hi, ACQ_CYC);
        check_frame(0, 10'h155, "abort");
        repeat (150) @(negedge clk);
        chk(valid_cnt == base + 1, "R9 no strobe for aborted frame", valid_cnt - base, 1);

        // R11: request during a frame is served exactly once
        dev_val = 10'h3C3; mode_i = 2'd2; base = valid_cnt;
        pulse_start();
        while (rises < 3 || cs_n_o) @(negedge clk);
        pulse_start();
        wait_valid(base + 2);
        chk(last_cs_hi >= CSH_CYC && last_cs_hi <= CSH_CYC + 2, "R11 served on return", last_cs_hi, CSH_CYC + 1);
        check_frame(2, 10'h3C3, "pend");
        repeat (200) @(negedge clk);
        chk(valid_cnt == base + 2, "R11 served once", valid_cnt - base, 2);

        // R10: power-down holds off frames, release waits for wake-up
        @(posedge clk); #1 shdn_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(shdn_n_o == 1'b0 && cs_n_o == 1'b1, "R10 power-down", {shdn_n_o, cs_n_o}, 1);
        dev_val = 10'h0F0; mode_i = 2'd1; base = cs_falls;
        pulse_start();
        repeat (60) @(negedge clk);
        chk(cs_falls == base, "R10 no frame in power-down", cs_falls - base, 0);
        chk(shdn_n_o == 1'b0, "R10 line held", shdn_n_o, 0);
        base = valid_cnt;
        @(posedge clk); #1 shdn_req_i = 1'b0; t0 = cyc;
        wait_valid(base + 1);
        chk(cs_fall_cyc - t0 >= WAKE_CYC, "R10 wake after release", cs_fall_cyc - t0, WAKE_CYC);
        check_frame(1, 10'h0F0, "wake");

        chk(valid_pos_err == 0, "R7 strobe position", valid_pos_err, 0);
        chk(sclk_idle_err == 0, "R2 clock while deselected", sclk_idle_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule